// File: doc/BRIEF.md
# Wavefront Program Counter Sequencer

This unit keeps the program counter of one wavefront and works out where execution goes after each scalar instruction. The counter is a word index, and every scalar instruction is one word long. A decoded instruction arrives as a single-cycle strobe carrying a class, an opcode and a 16-bit immediate. Alongside it come the scalar condition bit, the 64-bit vector-condition mask, the 64-bit execute mask and a 64-bit jump source operand. From these the unit computes the next counter value.

Program-flow instructions cover several cases. There are relative branches, either unconditional or gated on the condition bit, the low half of the vector-condition mask, or the whole execute mask. There is a program end and a barrier. Opcodes with no control effect simply advance the counter. Single-source instructions read the counter out as a 64-bit byte address, or jump indirectly to a 64-bit byte address. Every other class advances the counter by one word.

A small state machine holds the unit in one of four states:

- `ST_RUN` accepts instructions.
- `ST_BARWAIT` is entered from `ST_RUN` on a barrier. It returns to `ST_RUN` when `resume_i` is pulsed.
- `ST_HALT` is entered from `ST_RUN` on program end and stays until reset.
- `ST_FAULT` is entered from `ST_RUN` on an invalid program-flow opcode and stays until reset.

In every state other than `ST_RUN`, instruction strobes are ignored.

Top module: `wave_pc_seq`

## Requirements
- R1: After reset the counter `pc_o` is 0, `ended_o`, `bar_wait_o`, `fault_o` and `getpc_we_o` are 0, and the unit is in `ST_RUN`.
- R2: The counter becomes the old counter plus 1, wrapping modulo 2^62, one clock edge after the strobe, for each of these instructions accepted in `ST_RUN`: program-flow (class 0) opcode 0 or any opcode from 10 to 61; single-source (class 1) opcode 2 to 127; class 2 or 3 with any opcode; and a conditional branch whose condition is false.
- R3: Program-flow opcode 2 is an unconditional branch. The new counter is the old counter + 1 + the sign-extended 16-bit immediate, modulo 2^62.
- R4: Program-flow opcode 4 branches (as in R3) only when `scc_i` is 0, and opcode 5 only when `scc_i` is 1.
- R5: Program-flow opcode 6 branches only when `vcc_i[31:0]` is zero, and opcode 7 only when it is nonzero. Bits [63:32] are ignored.
- R6: Program-flow opcode 8 branches only when all 64 bits of `exec_i` are zero, and opcode 9 only when any bit is set.
- R7: Single-source opcode 0 (get counter) has these effects one edge later:
  - `getpc_we_o` is 1 for exactly one cycle;
  - `getpc_data_o` is the instruction's own counter times 4;
  - the counter advances by 1.
- R8: Single-source opcode 1 (jump indirect) sets the new counter to `jump_src_i` divided by 4, that is bits [63:2]. A negative byte address therefore gives the matching word address modulo 2^62.
- R9: Program-flow opcode 1 (end) moves to `ST_HALT`. There `ended_o` is 1 and the counter stays at the end instruction's address. Later strobes and resume pulses have no effect until reset.
- R10: Program-flow opcode 3 (barrier) moves to `ST_BARWAIT`. There `bar_wait_o` is 1, the counter holds, and strobes are ignored. A `resume_i` pulse returns the unit to `ST_RUN` with the counter plus 1, even if a strobe arrives in the same cycle.
- R11: A program-flow opcode from 62 to 127 moves to `ST_FAULT`. There `fault_o` is 1 and stays 1, and the counter keeps the faulting instruction's address.
- R12: With no strobe, and no resume pulse while waiting at a barrier, the counter holds. A resume pulse in `ST_RUN` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_vld | input | 1 | Decoded instruction strobe |
| instr_cls | input | 2 | Class: 0 program-flow, 1 single-source, 2/3 other |
| instr_op | input | 7 | Opcode within class |
| instr_imm | input | 16 | Signed word branch offset |
| scc_i | input | 1 | Scalar condition bit |
| vcc_i | input | 64 | Vector condition mask |
| exec_i | input | 64 | Execute mask |
| jump_src_i | input | 64 | Byte address for indirect jump |
| resume_i | input | 1 | Barrier release pulse |
| pc_o | output | 62 | Word program counter |
| getpc_we_o | output | 1 | Get-counter write enable |
| getpc_data_o | output | 64 | Get-counter byte address |
| ended_o | output | 1 | Program ended |
| bar_wait_o | output | 1 | Waiting at barrier |
| fault_o | output | 1 | Invalid opcode seen |

## Verification
A barrier release and a new instruction strobe can arrive in the same cycle. The bench provokes this by parking the unit in `ST_BARWAIT` and then pulsing `resume_i` together with a taken branch strobe. It then checks two things: the counter moved by exactly one word rather than by the branch offset, and the wait flag dropped. A get-counter write and its counter advance share one edge as well. The bench judges both by comparing the written byte address against four times the counter value before the advance.

// File: rtl/wave_pc_pkg.sv
package wave_pc_pkg;

    localparam logic [1:0] CLS_FLOW = 2'd0;
    localparam logic [1:0] CLS_ONE  = 2'd1;

    localparam int unsigned FOP_NOP     = 0;
    localparam int unsigned FOP_END     = 1;
    localparam int unsigned FOP_BRA     = 2;
    localparam int unsigned FOP_BAR     = 3;
    localparam int unsigned FOP_SCC0    = 4;
    localparam int unsigned FOP_SCC1    = 5;
    localparam int unsigned FOP_VCCZ    = 6;
    localparam int unsigned FOP_VCCNZ   = 7;
    localparam int unsigned FOP_EXECZ   = 8;
    localparam int unsigned FOP_EXECNZ  = 9;
    localparam int unsigned FOP_MAX_OK  = 61;

    localparam int unsigned SOP_GETPC = 0;
    localparam int unsigned SOP_SETPC = 1;

    typedef enum logic [2:0] {
        ACT_STEP, ACT_BRA, ACT_CBR, ACT_END, ACT_BAR, ACT_GETPC, ACT_SETPC, ACT_BAD
    } act_t;

    typedef enum logic [2:0] {
        CND_ALWAYS, CND_SCC0, CND_SCC1, CND_VCCZ, CND_VCCNZ, CND_EXECZ, CND_EXECNZ
    } cnd_t;

    typedef enum logic [1:0] {
        NX_HOLD, NX_STEP, NX_BRA, NX_JUMP
    } nxsel_t;

    typedef enum logic [1:0] {
        ST_RUN, ST_BARWAIT, ST_HALT, ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
    import wave_pc_pkg::*;
#(
    parameter int OP_W = 7
) (
    input  logic [1:0]      cls,
    input  logic [OP_W-1:0] op,
    output act_t            act,
    output cnd_t            cnd
);
    always_comb begin
        act = ACT_STEP;
        cnd = CND_ALWAYS;
        if (cls == CLS_FLOW) begin
            if (int'(op) > FOP_MAX_OK) begin
                act = ACT_BAD;
            end else begin
                case (int'(op))
                    FOP_END:    act = ACT_END;
                    FOP_BRA:    act = ACT_BRA;
                    FOP_BAR:    act = ACT_BAR;
                    FOP_SCC0:   begin act = ACT_CBR; cnd = CND_SCC0;   end
                    FOP_SCC1:   begin act = ACT_CBR; cnd = CND_SCC1;   end
                    FOP_VCCZ:   begin act = ACT_CBR; cnd = CND_VCCZ;   end
                    FOP_VCCNZ:  begin act = ACT_CBR; cnd = CND_VCCNZ;  end
                    FOP_EXECZ:  begin act = ACT_CBR; cnd = CND_EXECZ;  end
                    FOP_EXECNZ: begin act = ACT_CBR; cnd = CND_EXECNZ; end
                    default:    act = ACT_STEP;
                endcase
            end
        end else if (cls == CLS_ONE) begin
            if (int'(op) == SOP_GETPC)      act = ACT_GETPC;
            else if (int'(op) == SOP_SETPC) act = ACT_SETPC;
        end
    end
endmodule

// File: rtl/wpc_cond.sv
module wpc_cond
    import wave_pc_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int VTEST_W = 32
) (
    input  cnd_t              cnd,
    input  logic              scc,
    input  logic [MASK_W-1:0] vcc,
    input  logic [MASK_W-1:0] exec_m,
    output logic              taken
);
    logic vcc_zero;
    logic exec_zero;

    assign vcc_zero  = (vcc[VTEST_W-1:0] == '0);
    assign exec_zero = (exec_m == '0);

    always_comb begin
        unique case (cnd)
            CND_ALWAYS: taken = 1'b1;
            CND_SCC0:   taken = ~scc;
            CND_SCC1:   taken = scc;
            CND_VCCZ:   taken = vcc_zero;
            CND_VCCNZ:  taken = ~vcc_zero;
            CND_EXECZ:  taken = exec_zero;
            CND_EXECNZ: taken = ~exec_zero;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/wpc_target.sv
module wpc_target
    import wave_pc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IMM_W = 16,
    localparam int PC_W = ADDR_W - 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] jsrc,
    input  nxsel_t            sel,
    output logic [PC_W-1:0]   nxt
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] ofs;

    assign seq_pc = pc + PC_W'(1);
    assign ofs    = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        unique case (sel)
            NX_HOLD: nxt = pc;
            NX_STEP: nxt = seq_pc;
            NX_BRA:  nxt = seq_pc + ofs;
            NX_JUMP: nxt = jsrc[ADDR_W-1:2];
            default: nxt = pc;
        endcase
    end
endmodule

// File: rtl/wave_pc_seq.sv
module wave_pc_seq
    import wave_pc_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MASK_W = 64,
    parameter int VTEST_W = 32,
    parameter int IMM_W = 16,
    parameter int OP_W = 7,
    localparam int PC_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [1:0]        instr_cls,
    input  logic [OP_W-1:0]   instr_op,
    input  logic [IMM_W-1:0]  instr_imm,
    input  logic              scc_i,
    input  logic [MASK_W-1:0] vcc_i,
    input  logic [MASK_W-1:0] exec_i,
    input  logic [ADDR_W-1:0] jump_src_i,
    input  logic              resume_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              getpc_we_o,
    output logic [ADDR_W-1:0] getpc_data_o,
    output logic              ended_o,
    output logic              bar_wait_o,
    output logic              fault_o
);
    seq_state_t      state_q, state_d;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    nxsel_t          sel;
    act_t            act;
    cnd_t            cnd;
    logic            taken;
    logic            gp_fire;

    wpc_decode #(.OP_W(OP_W)) u_dec (
        .cls(instr_cls), .op(instr_op), .act(act), .cnd(cnd)
    );

    wpc_cond #(.MASK_W(MASK_W), .VTEST_W(VTEST_W)) u_cnd (
        .cnd(cnd), .scc(scc_i), .vcc(vcc_i), .exec_m(exec_i), .taken(taken)
    );

    wpc_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_tgt (
        .pc(pc_q), .imm(instr_imm), .jsrc(jump_src_i), .sel(sel), .nxt(pc_nxt)
    );

    // next-state and counter select
    always_comb begin
        state_d = state_q;
        sel     = NX_HOLD;
        gp_fire = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (instr_vld) begin
                    unique case (act)
                        ACT_STEP:  sel = NX_STEP;
                        ACT_BRA:   sel = NX_BRA;
                        ACT_CBR:   sel = taken ? NX_BRA : NX_STEP;
                        ACT_GETPC: begin sel = NX_STEP; gp_fire = 1'b1; end
                        ACT_SETPC: sel = NX_JUMP;
                        ACT_END:   state_d = ST_HALT;
                        ACT_BAR:   state_d = ST_BARWAIT;
                        ACT_BAD:   state_d = ST_FAULT;
                        default:   sel = NX_HOLD;
                    endcase
                end
            end
            ST_BARWAIT: begin
                if (resume_i) begin
                    state_d = ST_RUN;
                    sel     = NX_STEP;
                end
            end
            ST_HALT:  state_d = ST_HALT;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q         <= '0;
            getpc_we_o   <= 1'b0;
            getpc_data_o <= '0;
        end else begin
            pc_q       <= pc_nxt;
            getpc_we_o <= gp_fire;
            if (gp_fire) getpc_data_o <= {pc_q, 2'b00};
        end
    end

    assign pc_o       = pc_q;
    assign ended_o    = (state_q == ST_HALT);
    assign bar_wait_o = (state_q == ST_BARWAIT);
    assign fault_o    = (state_q == ST_FAULT);
endmodule

// File: rtl/wave_pc_seq_chk.sv
module wave_pc_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int OP_W = 7,
    localparam int PC_W = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_vld,
    input logic [1:0]        instr_cls,
    input logic [OP_W-1:0]   instr_op,
    input logic              resume_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              getpc_we_o,
    input logic [ADDR_W-1:0] getpc_data_o,
    input logic              ended_o,
    input logic              bar_wait_o,
    input logic              fault_o
);
    logic running;
    assign running = !ended_o && !bar_wait_o && !fault_o;

    // R1
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ended_o, bar_wait_o, fault_o}));

    // R2
    other_cls_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && instr_vld && instr_cls[1]) |=> (pc_o == $past(pc_o) + PC_W'(1)));

    // R7
    getpc_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        getpc_we_o |-> (getpc_data_o[1:0] == 2'b00 && getpc_data_o[ADDR_W-1:2] == pc_o - PC_W'(1)));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ended_o |=> (ended_o && $stable(pc_o)));

    // R10
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_wait_o && !resume_i) |=> (bar_wait_o && $stable(pc_o)));

    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (fault_o && $stable(pc_o)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_vld && !resume_i) |=> $stable(pc_o));
endmodule

bind wave_pc_seq wave_pc_seq_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (.*);

// File: tb/wave_pc_seq_test.sv
module wave_pc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [1:0]  instr_cls = '0;
    logic [6:0]  instr_op = '0;
    logic [15:0] instr_imm = '0;
    logic        scc_i = 1'b0;
    logic [63:0] vcc_i = '0;
    logic [63:0] exec_i = '0;
    logic [63:0] jump_src_i = '0;
    logic        resume_i = 1'b0;
    logic [61:0] pc_o;
    logic        getpc_we_o;
    logic [63:0] getpc_data_o;
    logic        ended_o, bar_wait_o, fault_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [61:0] exp_pc;

    always #2.5 clk = ~clk;

    wave_pc_seq uut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_cls(instr_cls),
        .instr_op(instr_op), .instr_imm(instr_imm), .scc_i(scc_i), .vcc_i(vcc_i),
        .exec_i(exec_i), .jump_src_i(jump_src_i), .resume_i(resume_i), .pc_o(pc_o),
        .getpc_we_o(getpc_we_o), .getpc_data_o(getpc_data_o), .ended_o(ended_o),
        .bar_wait_o(bar_wait_o), .fault_o(fault_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_pc(input string tag);
        chk(pc_o == exp_pc, tag, 64'(pc_o), 64'(exp_pc));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_vld = 1'b0;
        resume_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pc = '0;
    endtask

    task automatic issue(input logic [1:0] c, input logic [6:0] o, input logic [15:0] im);
        instr_cls = c;
        instr_op = o;
        instr_imm = im;
        instr_vld = 1'b1;
        @(negedge clk);
        instr_vld = 1'b0;
    endtask

    task automatic set_pc(input logic [63:0] byte_addr);
        jump_src_i = byte_addr;
        issue(2'd1, 7'd1, 16'h0);
        exp_pc = byte_addr[63:2];
    endtask

    function automatic logic [61:0] bra(input logic [61:0] p, input logic [15:0] im);
        return p + 62'd1 + {{46{im[15]}}, im};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(pc_o == 62'd0, "R1 pc", 64'(pc_o), 64'd0);
        chk({ended_o, bar_wait_o, fault_o, getpc_we_o} == 4'b0, "R1 flags",
            64'({ended_o, bar_wait_o, fault_o, getpc_we_o}), 64'd0);

        // R2 step sweep over non-control flow ops
        for (int op = 0; op <= 61; op++) begin
            if (op == 0 || op >= 10) begin
                issue(2'd0, 7'(op), 16'h8001);
                exp_pc = exp_pc + 62'd1;
                chk_pc("R2 flow step");
            end
        end
        for (int op = 2; op < 128; op++) begin
            issue(2'd1, 7'(op), 16'hFFFF);
            exp_pc = exp_pc + 62'd1;
            chk_pc("R2 single-source step");
        end
        for (int c = 2; c < 4; c++) begin
            for (int op = 0; op < 128; op += 9) begin
                issue(2'(c), 7'(op), 16'h4000);
                exp_pc = exp_pc + 62'd1;
                chk_pc("R2 other class step");
            end
        end
        // R2 wrap at top of counter space
        set_pc(64'hFFFF_FFFF_FFFF_FFFC);
        chk_pc("R8 set to top");
        issue(2'd0, 7'd0, 16'h0);
        exp_pc = '0;
        chk_pc("R2 wrap");

        // R3 unconditional branch sweep
        set_pc(64'h0000_0000_0004_0000);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] im;
            im = 16'(k * 16'h1111);
            exp_pc = bra(exp_pc, im);
            issue(2'd0, 7'd2, im);
            chk_pc("R3 branch");
        end
        set_pc(64'h0);
        issue(2'd0, 7'd2, 16'hFFFF);
        chk_pc("R3 branch minus one at zero");
        issue(2'd0, 7'd2, 16'h8000);
        exp_pc = bra(62'd0, 16'h8000);
        chk_pc("R3 backward wrap");

        // R8 indirect jumps
        set_pc(64'hFFFF_FFFF_FFFF_FFF8);
        chk(pc_o == 62'h3FFF_FFFF_FFFF_FFFE, "R8 negative target", 64'(pc_o), 64'h3FFF_FFFF_FFFF_FFFE);
        set_pc(64'h0000_0000_0000_0007);
        chk(pc_o == 62'd1, "R8 unaligned", 64'(pc_o), 64'd1);
        set_pc(64'h1234_5678_9ABC_DEF0);
        chk_pc("R8 wide target");

        // R4 R5 R6 conditional sweep
        for (int op = 4; op <= 9; op++) begin
            for (int s = 0; s < 2; s++) begin
                for (int v = 0; v < 3; v++) begin
                    for (int e = 0; e < 3; e++) begin
                        bit tk;
                        logic [63:0] vv, ee;
                        vv = (v == 0) ? 64'h0 : (v == 1) ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_0001_0000;
                        ee = (e == 0) ? 64'h0 : (e == 1) ? 64'h8000_0000_0000_0000 : 64'h1;
                        case (op)
                            4: tk = (s == 0);
                            5: tk = (s == 1);
                            6: tk = (vv[31:0] == 0);
                            7: tk = (vv[31:0] != 0);
                            8: tk = (ee == 0);
                            default: tk = (ee != 0);
                        endcase
                        scc_i = 1'(s);
                        vcc_i = vv;
                        exec_i = ee;
                        exp_pc = tk ? bra(exp_pc, 16'hFFF0) : exp_pc + 62'd1;
                        issue(2'd0, 7'(op), 16'hFFF0);
                        if (op < 6) chk_pc("R4 scc branch");
                        else if (op < 8) chk_pc("R5 vcc branch");
                        else chk_pc("R6 exec branch");
                    end
                end
            end
        end

        // R7 get counter
        set_pc(64'h0000_00AB_CDEF_0010);
        issue(2'd1, 7'd0, 16'h0);
        chk(getpc_we_o == 1'b1, "R7 write enable", 64'(getpc_we_o), 64'd1);
        chk(getpc_data_o == 64'h0000_00AB_CDEF_0010, "R7 data", getpc_data_o, 64'h0000_00AB_CDEF_0010);
        exp_pc = exp_pc + 62'd1;
        chk_pc("R7 advance");
        @(negedge clk);
        chk(getpc_we_o == 1'b0, "R7 single pulse", 64'(getpc_we_o), 64'd0);

        // R12 idle and stray resume
        repeat (3) @(negedge clk);
        chk_pc("R12 idle hold");
        resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
        chk_pc("R12 resume in run");

        // R10 barrier
        issue(2'd0, 7'd3, 16'h0);
        chk(bar_wait_o == 1'b1, "R10 flag", 64'(bar_wait_o), 64'd1);
        chk_pc("R10 hold");
        issue(2'd0, 7'd2, 16'h0100);
        chk_pc("R10 strobe ignored");
        resume_i = 1'b1;
        issue(2'd0, 7'd2, 16'h0100);
        resume_i = 1'b0;
        exp_pc = exp_pc + 62'd1;
        chk_pc("R10 release with strobe");
        chk(bar_wait_o == 1'b0, "R10 flag clear", 64'(bar_wait_o), 64'd0);

        // R9 end
        issue(2'd0, 7'd1, 16'h0);
        chk(ended_o == 1'b1, "R9 flag", 64'(ended_o), 64'd1);
        issue(2'd0, 7'd2, 16'h0020);
        resume_i = 1'b1;
        @(negedge clk);
        resume_i = 1'b0;
        chk_pc("R9 halted hold");
        chk(ended_o == 1'b1, "R9 sticky", 64'(ended_o), 64'd1);

        // R11 invalid opcode sweep
        for (int op = 62; op < 128; op++) begin
            do_reset();
            set_pc(64'(op) << 4);
            issue(2'd0, 7'(op), 16'h0005);
            chk(fault_o == 1'b1, "R11 fault flag", 64'(fault_o), 64'd1);
            chk_pc("R11 pc held");
            issue(2'd1, 7'd1, 16'h0);
            chk(fault_o == 1'b1 && pc_o == exp_pc, "R11 sticky", 64'(pc_o), 64'(exp_pc));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule